// File: doc/BRIEF.md
# Multi-Lane SECDED Read Decoder

This block sits on the read return path of a memory that stores data with single-error-correct, double-error-detect protection. Each input beat carries several packed codewords side by side. The block splits the beat into lanes and decodes each lane on its own. For each lane it computes a Hamming syndrome and an overall parity, and from these it repairs any one flipped bit or reports a double error. The recovered data lanes are then packed into a narrower output beat.

The output beat, its valid strobe and two per-beat flags are registered, so they appear one clock after the input beat. The flags say whether some lane held a single error and whether some lane held a double error. Two saturating event counters add up the affected lanes across beats. An enable input turns decoding off: data then passes straight through and nothing is reported. A clear input zeroes both counters.

Each lane decoder puts its codeword into one of three named states. LANE_CLEAN means a zero syndrome with good parity. LANE_SINGLE means bad parity with a syndrome of zero or a syndrome inside the codeword. LANE_DOUBLE means good parity with a nonzero syndrome, or bad parity with a syndrome beyond the last position. The choice depends only on the current codeword. Every lane is forced to LANE_CLEAN while enable is low.

Top module: `secded_rd_decoder`

## Requirements
- R1: With the default DATA_W=32, each lane is 39 bits and sits at in_data[i*CODE_W +: CODE_W]. Bit 0 is even parity over the whole codeword. Bits 1..CODE_W-1 are Hamming positions 1..CODE_W-1. Check bits sit at the power-of-two positions. Data bits fill the remaining positions in ascending order, LSB first. Data lane i leaves at out_data[i*DATA_W +: DATA_W]. A clean codeword returns its data unchanged with both flags low.
- R2: out_valid equals in_valid delayed by one clock. out_data, sec_flag and ded_flag change only on a valid beat, and they appear one clock after it. out_data holds its value between valid beats.
- R3: With enable high, any single flipped bit is corrected and raises sec_flag without ded_flag. This includes the parity bit and the check bits.
- R4: With enable high, two flipped bits in a lane raise ded_flag. That lane's data is extracted from the received bits without correction. If no other lane has a single error, sec_flag stays low.
- R5: sec_flag and ded_flag stay low, and the counters do not move, while in_valid is low, whatever the input data.
- R6: While enable is low, no bit is corrected: data is extracted raw. Both flags stay low and the counters hold, even when bits are flipped.
- R7: On each valid beat, sec_count grows by the number of lanes in LANE_SINGLE and ded_count by the number of lanes in LANE_DOUBLE. The new counts are visible one clock after the beat.
- R8: Each counter stops at 2**CNT_W-1 and never wraps.
- R9: A one-cycle clear zeroes both counters at the next clock edge. Clear takes priority over any increment in the same cycle.
- R10: A lane with bad overall parity and a syndrome greater than CODE_W-1 is reported as a double error, not corrected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Decode enable; low passes raw data and reports nothing |
| clear | input | 1 | Zeroes both event counters |
| in_valid | input | 1 | Input beat valid |
| in_data | input | LANES*CODE_W | Packed codewords |
| out_valid | output | 1 | Output beat valid |
| out_data | output | LANES*DATA_W | Packed decoded data |
| sec_flag | output | 1 | Some lane held a single error in this beat |
| ded_flag | output | 1 | Some lane held a double error in this beat |
| sec_count | output | CNT_W | Saturating single-error lane count |
| ded_count | output | CNT_W | Saturating double-error lane count |

## Verification
A wrong syndrome or parity calculation shows up one clock after the beat. The output data then differs from the encoded data in one lane, or the flag that fires does not match the injected error. A counter that adds the wrong amount, wraps, or ignores clear is wrong on the very next cycle. The bench checks the counts after every beat, so the error stays visible from then on. The sweeps cover every single-bit position and every pair of positions in a small configuration. Because of this, a wrong bit position in the correction or extraction logic cannot hide.

// File: rtl/secded_pkg.sv
package secded_pkg;

    typedef enum logic [1:0] {
        LANE_CLEAN  = 2'd0,
        LANE_SINGLE = 2'd1,
        LANE_DOUBLE = 2'd2
    } lane_state_e;

    // number of Hamming check bits needed for a data width
    function automatic int check_bits(input int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // Hamming position of data bit k among positions 1..n
    function automatic int data_pos(input int k, input int n);
        int seen;
        int res;
        seen = 0;
        res  = 0;
        for (int i = 1; i <= n; i++) begin
            if (!is_pow2(i)) begin
                if (seen == k) res = i;
                seen++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/secded_lane_dec.sv
module secded_lane_dec
    import secded_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int CHK_W  = check_bits(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W + 1
) (
    input  logic              enable,
    input  logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] data,
    output lane_state_e       state
);
    localparam int LAST_POS = CODE_W - 1;

    logic [CHK_W-1:0]  syndrome;
    logic              par_bad;
    logic              syn_nz;
    logic              syn_in_range;
    logic [CODE_W-1:0] fixed;

    always_comb begin
        syndrome = '0;
        for (int i = 1; i < CODE_W; i++) begin
            if (code[i]) syndrome = syndrome ^ CHK_W'(i);
        end
    end

    assign par_bad      = ^code;
    assign syn_nz       = (syndrome != '0);
    assign syn_in_range = (syndrome <= CHK_W'(LAST_POS));

    always_comb begin
        state = LANE_CLEAN;
        if (enable) begin
            unique case ({par_bad, syn_nz})
                2'b00: state = LANE_CLEAN;
                2'b01: state = LANE_DOUBLE;
                2'b10: state = LANE_SINGLE;
                2'b11: state = syn_in_range ? LANE_SINGLE : LANE_DOUBLE;
                default: state = LANE_CLEAN;
            endcase
        end
    end

    always_comb begin
        fixed = code;
        if (state == LANE_SINGLE) begin
            for (int i = 1; i < CODE_W; i++) begin
                if (syndrome == CHK_W'(i)) fixed[i] = ~code[i];
            end
        end
    end

    for (genvar k = 0; k < DATA_W; k++) begin : g_extract
        localparam int DPOS = data_pos(k, LAST_POS);
        assign data[k] = fixed[DPOS];
    end

endmodule

// File: rtl/secded_sat_counter.sv
module secded_sat_counter #(
    parameter int CNT_W = 16,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] count_next;

    assign sum        = {1'b0, count} + (CNT_W + 1)'(inc);
    assign count_next = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else            count <= count_next;
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0)); // R9

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && count == CNT_MAX) |=> (count == CNT_MAX)); // R8

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (count >= $past(count))); // R8

endmodule

// File: rtl/secded_rd_decoder.sv
module secded_rd_decoder
    import secded_pkg::*;
#(
    parameter  int LANES  = 8,
    parameter  int DATA_W = 32,
    parameter  int CNT_W  = 16,
    localparam int CODE_W = DATA_W + check_bits(DATA_W) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    clear,
    input  logic                    in_valid,
    input  logic [LANES*CODE_W-1:0] in_data,
    output logic                    out_valid,
    output logic [LANES*DATA_W-1:0] out_data,
    output logic                    sec_flag,
    output logic                    ded_flag,
    output logic [CNT_W-1:0]        sec_count,
    output logic [CNT_W-1:0]        ded_count
);
    localparam int HIT_W = $clog2(LANES + 1);

    lane_state_e               lane_state [LANES];
    logic [LANES*DATA_W-1:0]   dec_data;
    logic [LANES-1:0]          sec_hit;
    logic [LANES-1:0]          ded_hit;
    logic [HIT_W-1:0]          sec_inc;
    logic [HIT_W-1:0]          ded_inc;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        secded_lane_dec #(.DATA_W(DATA_W)) u_dec (
            .enable (enable),
            .code   (in_data[l*CODE_W +: CODE_W]),
            .data   (dec_data[l*DATA_W +: DATA_W]),
            .state  (lane_state[l])
        );
        assign sec_hit[l] = in_valid && (lane_state[l] == LANE_SINGLE);
        assign ded_hit[l] = in_valid && (lane_state[l] == LANE_DOUBLE);
    end

    always_comb begin
        sec_inc = '0;
        ded_inc = '0;
        for (int l = 0; l < LANES; l++) begin
            sec_inc = sec_inc + HIT_W'(sec_hit[l]);
            ded_inc = ded_inc + HIT_W'(ded_hit[l]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            sec_flag  <= 1'b0;
            ded_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            sec_flag  <= |sec_hit;
            ded_flag  <= |ded_hit;
            if (in_valid) out_data <= dec_data;
        end
    end

    secded_sat_counter #(.CNT_W(CNT_W), .INC_W(HIT_W)) u_sec_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .inc   (sec_inc),
        .count (sec_count)
    );

    secded_sat_counter #(.CNT_W(CNT_W), .INC_W(HIT_W)) u_ded_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .inc   (ded_inc),
        .count (ded_count)
    );

    AST_OUT_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid))); // R2

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data)); // R2

    AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!sec_flag && !ded_flag)); // R5

    AST_IDLE_COUNTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clear) |=> ($stable(sec_count) && $stable(ded_count))); // R5

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clear) |=> (!sec_flag && !ded_flag && $stable(sec_count) && $stable(ded_count))); // R6

endmodule

// File: tb/tb_secded_rd_decoder.sv
module tb_secded_rd_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 2;
    localparam int DW     = 8;
    localparam int CW     = 13;
    localparam int CNT_W  = 4;
    localparam int CMAX   = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b1;
    logic              clear = 1'b0;
    logic              in_valid = 1'b0;
    logic [LANES*CW-1:0] in_data = '0;
    logic              out_valid;
    logic [LANES*DW-1:0] out_data;
    logic              sec_flag;
    logic              ded_flag;
    logic [CNT_W-1:0]  sec_count;
    logic [CNT_W-1:0]  ded_count;

    int checks = 0;
    int fails  = 0;
    int exp_sec = 0;
    int exp_ded = 0;
    logic [DW-1:0] last0 = '0;
    logic [DW-1:0] last1 = '0;
    bit done = 0;

    secded_rd_decoder #(.LANES(LANES), .DATA_W(DW), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
        .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
        .out_data(out_data), .sec_flag(sec_flag), .ded_flag(ded_flag),
        .sec_count(sec_count), .ded_count(ded_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [CW-1:0] enc(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int i = 1; i < CW; i++) begin
            if ((i & (i - 1)) != 0) begin
                c[i] = d[k];
                k++;
            end
        end
        for (int p = 0; p < 4; p++) begin
            logic x;
            x = 1'b0;
            for (int i = 1; i < CW; i++)
                if (((i & (1 << p)) != 0) && ((i & (i - 1)) != 0)) x = x ^ c[i];
            c[1 << p] = x;
        end
        c[0] = ^c[CW-1:1];
        return c;
    endfunction

    function automatic logic [DW-1:0] ext(input logic [CW-1:0] c);
        logic [DW-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int i = 1; i < CW; i++) begin
            if ((i & (i - 1)) != 0) begin
                d[k] = c[i];
                k++;
            end
        end
        return d;
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // drive at negedge, sample at the following negedge (one posedge later)
    task automatic beat(input logic [CW-1:0] c0, input logic [CW-1:0] c1,
                        input logic v, input logic en, input logic clr,
                        input logic [DW-1:0] e0, input logic [DW-1:0] e1,
                        input logic es, input logic ed, input int ns, input int nd,
                        input string rq);
        in_data  = {c1, c0};
        in_valid = v;
        enable   = en;
        clear    = clr;
        @(negedge clk);
        if (clr) begin
            exp_sec = 0;
            exp_ded = 0;
        end else if (v && en) begin
            exp_sec = (exp_sec + ns > CMAX) ? CMAX : exp_sec + ns;
            exp_ded = (exp_ded + nd > CMAX) ? CMAX : exp_ded + nd;
        end
        if (v) begin
            last0 = e0;
            last1 = e1;
        end
        chk(rq, "out_valid", 32'(out_valid), 32'(v));
        chk(rq, "out_data", 32'(out_data), 32'({last1, last0}));
        chk(rq, "sec_flag", 32'(sec_flag), 32'(v && en && es));
        chk(rq, "ded_flag", 32'(ded_flag), 32'(v && en && ed));
        chk(rq, "sec_count", 32'(sec_count), 32'(exp_sec));
        chk(rq, "ded_count", 32'(ded_count), 32'(exp_ded));
        in_valid = 1'b0;
        clear    = 1'b0;
        enable   = 1'b1;
    endtask

    task automatic do_clear();
        beat('0, '0, 1'b0, 1'b1, 1'b1, last0, last1, 1'b0, 1'b0, 0, 0, "R9");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] c;
        @(negedge clk);
        @(negedge clk);
        chk("R2", "reset out_valid", 32'(out_valid), 32'd0);
        chk("R5", "reset flags", 32'({sec_flag, ded_flag}), 32'd0);
        chk("R9", "reset counts", 32'({sec_count, ded_count}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every data value, clean codewords
        for (int d = 0; d < 256; d++)
            beat(enc(8'(d)), enc(~8'(d)), 1'b1, 1'b1, 1'b0, 8'(d), ~8'(d),
                 1'b0, 1'b0, 0, 0, "R1");

        // R3: every single-bit position, both lanes, several data values
        for (int pos = 0; pos < CW; pos++) begin
            for (int s = 0; s < 4; s++) begin
                logic [DW-1:0] d;
                d = (s == 0) ? 8'h00 : (s == 1) ? 8'hA5 : (s == 2) ? 8'hFF : 8'h3C;
                beat(enc(d) ^ (CW'(1) << pos), enc(d + 8'd1), 1'b1, 1'b1, 1'b0,
                     d, d + 8'd1, 1'b1, 1'b0, 1, 0, "R3");
                beat(enc(d), enc(~d) ^ (CW'(1) << pos), 1'b1, 1'b1, 1'b0,
                     d, ~d, 1'b1, 1'b0, 1, 0, "R3");
            end
        end

        // R4: every pair of positions in lane 1
        do_clear();
        for (int i = 0; i < CW; i++) begin
            for (int j = i + 1; j < CW; j++) begin
                c = enc(8'h5A) ^ (CW'(1) << i) ^ (CW'(1) << j);
                beat(enc(8'hC3), c, 1'b1, 1'b1, 1'b0, 8'hC3, ext(c),
                     1'b0, 1'b1, 0, 1, "R4");
            end
        end

        // R10: bad parity with syndrome 13 (beyond last position 12)
        c = enc(8'h96) ^ (CW'(1) << 0) ^ (CW'(1) << 1) ^ (CW'(1) << 12);
        beat(c, enc(8'h11), 1'b1, 1'b1, 1'b0, ext(c), 8'h11, 1'b0, 1'b1, 0, 1, "R10");

        // R9: clear together with an erroring beat wins
        beat(enc(8'h01) ^ CW'(8), enc(8'h02) ^ CW'(16), 1'b1, 1'b1, 1'b1,
             8'h01, 8'h02, 1'b1, 1'b0, 2, 0, "R9");
        chk("R9", "sec_count zero", 32'(sec_count), 32'd0);

        // R7: per-lane accumulation
        beat(enc(8'h10) ^ CW'(8), enc(8'h20) ^ CW'(32), 1'b1, 1'b1, 1'b0,
             8'h10, 8'h20, 1'b1, 1'b0, 2, 0, "R7");
        chk("R7", "sec_count two", 32'(sec_count), 32'd2);
        c = enc(8'h40) ^ CW'(6);
        beat(enc(8'h30) ^ CW'(1), c, 1'b1, 1'b1, 1'b0,
             8'h30, ext(c), 1'b1, 1'b1, 1, 1, "R7");
        chk("R7", "counts 3/1", 32'({sec_count, ded_count}), 32'({4'd3, 4'd1}));

        // R5: invalid beats with errors have no effect
        c = enc(8'h77) ^ CW'(3);
        beat(c, c, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 2, 2, "R5");
        beat(enc(8'h77) ^ CW'(1), c, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1, 1, "R5");

        // R6: disabled, raw extraction, nothing reported
        c = enc(8'hE7) ^ CW'(1 << 3);
        beat(enc(8'h9C) ^ CW'(12), c, 1'b1, 1'b0, 1'b0,
             ext(enc(8'h9C) ^ CW'(12)), ext(c), 1'b0, 1'b0, 0, 0, "R6");
        chk("R6", "lane1 uncorrected", 32'(out_data[15:8]), 32'(8'hE7 ^ 8'h01));

        // R8: saturation
        do_clear();
        for (int n = 0; n < 10; n++)
            beat(enc(8'(n)) ^ CW'(4), enc(8'(n)) ^ CW'(2048), 1'b1, 1'b1, 1'b0,
                 8'(n), 8'(n), 1'b1, 1'b0, 2, 0, "R8");
        chk("R8", "sec_count saturated", 32'(sec_count), 32'(CMAX));

        // R2: hold after an idle cycle
        beat('0, '0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 0, 0, "R2");
        chk("R2", "data held", 32'(out_data), 32'({8'd9, 8'd9}));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule